// File: doc/BRIEF.md
# Four-Level Interrupt Priority Arbiter

This block collects interrupt requests from seven sources and offers one of them at a time to a processor core, together with the service routine address and the priority level of the offered request. Five sources are internal peripherals whose flags arrive as one-cycle pulses. Two are external pins, active low, and each can be set to trigger on a falling edge or on a low level. Each source is gated by its own enable bit, and all sources are also gated by one global enable. Each source has a pair of priority bits, which gives four levels.

The core takes a request by pulsing an acknowledge. The arbiter then records the level as in service. From that point only requests at a strictly higher level can preempt. A return strobe ends the innermost service level, which allows lower pending requests to be offered again. When two pending requests share the highest eligible level, a fixed polling order picks between them.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` is 0, `irq_lvl` is 0 and `svc_active` is 0.
- R2: Source indices follow the polling order: 0 external 0, 1 watchdog, 2 timer 0, 3 external 1, 4 timer 1, 5 serial, 6 timer 2. The vectors are 0003h, 0053h, 000Bh, 0013h, 001Bh, 0023h and 002Bh in that index order. An event sampled high on one rising edge makes the request, vector and level visible after the second rising edge.
- R3: A source is offered only while its `src_en` bit and `glob_en` are both 1. A masked pending flag is kept, and it is offered one edge after the mask is lifted.
- R4: The level of source i is {`prio_hi[i]`, `prio_lo[i]`}. Among eligible pending sources, the highest level is offered.
- R5: Among eligible pending sources at the same level, the lowest source index wins.
- R6: When `ext_edge_mode` bit k is 1 (bit 0 is external 0, bit 1 is external 1), a high-to-low transition of `ext_pin_n[k]` latches a pending flag. Acknowledge clears the flag. A pin that stays low does not trigger again.
- R7: When `ext_edge_mode` bit k is 0, the pending flag follows the inverted pin, one edge late, whether or not the source has been acknowledged.
- R8: A request is offered only if its level is strictly above the highest level in service. An equal or lower level waits.
- R9: An acknowledge while `irq_req` is 1 pushes `irq_lvl` as in service, clears that source's edge or pulse flag, and drops `irq_req` for one cycle. During that cycle `irq_vec` and `irq_lvl` keep their values.
- R10: `irq_ret` removes the highest level in service, one edge later. With nothing in service, it has no effect.
- R11: An acknowledge while `irq_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 7 | Per-source enable, indexed by polling order |
| prio_hi | input | 7 | Upper priority bit per source |
| prio_lo | input | 7 | Lower priority bit per source |
| ext_edge_mode | input | 2 | 1 = falling edge, 0 = low level, per external pin |
| ext_pin_n | input | 2 | External request pins, active low |
| wdog_evt | input | 1 | Watchdog event pulse |
| tmr0_evt | input | 1 | Timer 0 event pulse |
| tmr1_evt | input | 1 | Timer 1 event pulse |
| ser_evt | input | 1 | Serial event pulse |
| tmr2_evt | input | 1 | Timer 2 event pulse |
| irq_ack | input | 1 | Core takes the offered request |
| irq_ret | input | 1 | Core leaves the current service routine |
| irq_req | output | 1 | A request is offered |
| irq_vec | output | VEC_W (16) | Service routine address of the offered request |
| irq_lvl | output | 2 | Level of the offered request |
| svc_active | output | 1 | At least one level is in service |
| svc_lvl | output | 2 | Highest level in service |

## Verification
The path from an event to the outputs has two registers: the pending flag and the output register. A request driven around one rising edge is therefore checked after the second rising edge. A change of an enable or of the in-service state alters the offer one edge later. Acknowledge and return change `svc_active` and `svc_lvl` after one edge. The `irq_req` that follows an acknowledge or a return is due one edge after that. The bench changes inputs on falling edges and counts rising edges before each check, which it makes on a falling edge. Timing never depends on the order of processes at an edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int NSRC  = 7;
   localparam int LVL_W = 2;
   localparam int NLVL  = 1 << LVL_W;
   localparam int IDX_W = $clog2(NSRC);

   typedef enum logic [IDX_W-1:0] {
      SRC_X0  = 3'd0,
      SRC_WD  = 3'd1,
      SRC_T0  = 3'd2,
      SRC_X1  = 3'd3,
      SRC_T1  = 3'd4,
      SRC_SER = 3'd5,
      SRC_T2  = 3'd6
   } src_e;

   typedef logic [LVL_W-1:0] lvl_t;

   // Service routine address for each polling index.
   function automatic logic [15:0] vec_of(input logic [IDX_W-1:0] idx);
      case (idx)
         SRC_X0:  vec_of = 16'h0003;
         SRC_WD:  vec_of = 16'h0053;
         SRC_T0:  vec_of = 16'h000B;
         SRC_X1:  vec_of = 16'h0013;
         SRC_T1:  vec_of = 16'h001B;
         SRC_SER: vec_of = 16'h0023;
         SRC_T2:  vec_of = 16'h002B;
         default: vec_of = 16'h0000;
      endcase
   endfunction
endpackage

// File: rtl/irq_ext_latch.sv
module irq_ext_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic pend
);
   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b1;
         pend  <= 1'b0;
      end else begin
         pin_q <= pin_n;
         if (!edge_mode)
            pend <= ~pin_n;
         else if (pin_q && !pin_n)
            pend <= 1'b1;
         else if (clr)
            pend <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
   import irq_arb_pkg::*;
(
   input  logic [NSRC-1:0]            live,
   input  logic [NSRC-1:0][LVL_W-1:0] src_lvl,
   input  logic [NLVL-1:0]            svc_mask,
   output logic                       hit,
   output logic [IDX_W-1:0]           idx,
   output lvl_t                       lvl
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      lvl = '0;
      for (int i = 0; i < NSRC; i++) begin
         // eligible only when no level at or above this one is in service
         if (live[i] && ((svc_mask >> src_lvl[i]) == '0)) begin
            if (!hit || (src_lvl[i] > lvl)) begin
               hit = 1'b1;
               idx = IDX_W'(i);
               lvl = src_lvl[i];
            end
         end
      end
   end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
   import irq_arb_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  lvl_t            push_lvl,
   input  logic            pop,
   output logic [NLVL-1:0] mask,
   output logic            active,
   output lvl_t            top
);
   logic [NLVL-1:0] mask_n;

   always_comb begin
      top = '0;
      for (int i = 0; i < NLVL; i++)
         if (mask[i]) top = LVL_W'(i);
   end

   assign active = |mask;

   always_comb begin
      mask_n = mask;
      if (pop && active) mask_n[top] = 1'b0;
      if (push)          mask_n[push_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= '0;
      else        mask <= mask_n;
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int VEC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glob_en,
   input  logic [6:0]       src_en,
   input  logic [6:0]       prio_hi,
   input  logic [6:0]       prio_lo,
   input  logic [1:0]       ext_edge_mode,
   input  logic [1:0]       ext_pin_n,
   input  logic             wdog_evt,
   input  logic             tmr0_evt,
   input  logic             tmr1_evt,
   input  logic             ser_evt,
   input  logic             tmr2_evt,
   input  logic             irq_ack,
   input  logic             irq_ret,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   output logic [1:0]       irq_lvl,
   output logic             svc_active,
   output logic [1:0]       svc_lvl
);
   localparam int NPLS = 5;
   localparam int NEXT = 2;
   localparam int PLS_IDX [NPLS] = '{1, 2, 4, 5, 6};
   localparam int EXT_IDX [NEXT] = '{0, 3};

   if (VEC_W < 16) begin : g_bad_vec
      $error("irq_prio_arbiter: VEC_W must be at least 16");
   end
   if (NSRC != NPLS + NEXT) begin : g_bad_src
      $error("irq_prio_arbiter: source count mismatch");
   end

   logic [NSRC-1:0]            pend, clr, live;
   logic [NSRC-1:0][LVL_W-1:0] src_lvl;
   logic [NEXT-1:0]            ext_pend;
   logic [NPLS-1:0]            pls_pend;
   logic [NPLS-1:0]            pls_evt;
   logic [NLVL-1:0]            svc_mask;
   logic                       hit, take;
   logic [IDX_W-1:0]           pick_idx, idx_q;
   lvl_t                       pick_lvl, svc_top;
   logic                       req_q;
   logic [VEC_W-1:0]           vec_q;
   lvl_t                       lvl_q;

   assign pls_evt = {tmr2_evt, ser_evt, tmr1_evt, tmr0_evt, wdog_evt};
   assign take    = irq_ack && req_q;

   for (genvar s = 0; s < NSRC; s++) begin : g_clr
      assign clr[s]     = take && (idx_q == IDX_W'(s));
      assign src_lvl[s] = {prio_hi[s], prio_lo[s]};
   end

   for (genvar e = 0; e < NEXT; e++) begin : g_ext
      irq_ext_latch u_lat (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_n     (ext_pin_n[e]),
         .edge_mode (ext_edge_mode[e]),
         .clr       (clr[EXT_IDX[e]]),
         .pend      (ext_pend[e])
      );
   end

   for (genvar p = 0; p < NPLS; p++) begin : g_pls
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              pls_pend[p] <= 1'b0;
         else if (pls_evt[p])     pls_pend[p] <= 1'b1;
         else if (clr[PLS_IDX[p]]) pls_pend[p] <= 1'b0;
      end
   end

   assign pend = {pls_pend[4], pls_pend[3], pls_pend[2], ext_pend[1],
                  pls_pend[1], pls_pend[0], ext_pend[0]};
   assign live = pend & src_en & {NSRC{glob_en}};

   irq_pick u_pick (
      .live     (live),
      .src_lvl  (src_lvl),
      .svc_mask (svc_mask),
      .hit      (hit),
      .idx      (pick_idx),
      .lvl      (pick_lvl)
   );

   irq_svc_track u_svc (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take),
      .push_lvl (lvl_q),
      .pop      (irq_ret),
      .mask     (svc_mask),
      .active   (svc_active),
      .top      (svc_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         vec_q <= '0;
         lvl_q <= '0;
         idx_q <= '0;
      end else if (take) begin
         req_q <= 1'b0;
      end else begin
         req_q <= hit;
         if (hit) begin
            vec_q <= VEC_W'(vec_of(pick_idx));
            lvl_q <= pick_lvl;
            idx_q <= pick_idx;
         end
      end
   end

   assign irq_req = req_q;
   assign irq_vec = vec_q;
   assign irq_lvl = lvl_q;
   assign svc_lvl = svc_top;
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
   parameter int VEC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glob_en,
   input logic             irq_ack,
   input logic             irq_ret,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic [1:0]       irq_lvl,
   input logic             svc_active,
   input logic [1:0]       svc_lvl
);
   p_vec_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec[2:0] == 3'b011) && (irq_vec[VEC_W-1:7] == '0));

   p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> !irq_req);

   p_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && svc_active) |-> (irq_lvl > svc_lvl));

   p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !irq_req && $stable(irq_vec) && $stable(irq_lvl));

   p_ack_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> svc_active && (svc_lvl == $past(irq_lvl)));

   p_ret_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !svc_active && !(irq_ack && irq_req)) |=> !svc_active);

   p_ack_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !irq_req && !svc_active) |=> !svc_active);
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .glob_en    (glob_en),
   .irq_ack    (irq_ack),
   .irq_ret    (irq_ret),
   .irq_req    (irq_req),
   .irq_vec    (irq_vec),
   .irq_lvl    (irq_lvl),
   .svc_active (svc_active),
   .svc_lvl    (svc_lvl)
);

// File: tb/sim_irq_prio_arbiter.sv
module sim_irq_prio_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        glob_en = 1'b0;
   logic [6:0]  src_en = '0, prio_hi = '0, prio_lo = '0;
   logic [1:0]  ext_edge_mode = '0, ext_pin_n = 2'b11;
   logic        wdog_evt = 0, tmr0_evt = 0, tmr1_evt = 0, ser_evt = 0, tmr2_evt = 0;
   logic        irq_ack = 0, irq_ret = 0;
   logic        irq_req, svc_active;
   logic [15:0] irq_vec;
   logic [1:0]  irq_lvl, svc_lvl;

   int errors = 0, checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_prio_arbiter u0 (.*);

   // ev order: {tmr2, serial, tmr1, tmr0, watchdog}
   typedef struct packed {
      logic [3:0]  rq;
      logic        g;
      logic [6:0]  en, hi, lo;
      logic [4:0]  ev;
      logic        req;
      logic [15:0] vec;
      logic [1:0]  lvl;
   } vrow_t;

   localparam vrow_t TBL [8] = '{
      '{4'd2, 1'b1, 7'h7F, 7'h00, 7'h00, 5'b00010, 1'b1, 16'h000B, 2'd0},
      '{4'd5, 1'b1, 7'h7F, 7'h00, 7'h00, 5'b11111, 1'b1, 16'h0053, 2'd0},
      '{4'd4, 1'b1, 7'h7F, 7'h40, 7'h00, 5'b10100, 1'b1, 16'h002B, 2'd2},
      '{4'd4, 1'b1, 7'h7F, 7'h00, 7'h20, 5'b01010, 1'b1, 16'h0023, 2'd1},
      '{4'd3, 1'b0, 7'h7F, 7'h00, 7'h00, 5'b00010, 1'b0, 16'h0000, 2'd0},
      '{4'd3, 1'b1, 7'h6F, 7'h00, 7'h00, 5'b00100, 1'b0, 16'h0000, 2'd0},
      '{4'd5, 1'b1, 7'h7F, 7'h60, 7'h60, 5'b11000, 1'b1, 16'h0023, 2'd3},
      '{4'd4, 1'b1, 7'h7F, 7'h10, 7'h12, 5'b00101, 1'b1, 16'h001B, 2'd3}
   };

   task automatic negs(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; glob_en = 0; src_en = '0; prio_hi = '0; prio_lo = '0;
      ext_edge_mode = '0; ext_pin_n = 2'b11; irq_ack = 0; irq_ret = 0;
      {tmr2_evt, ser_evt, tmr1_evt, tmr0_evt, wdog_evt} = '0;
      negs(2);
      rst_n = 1;
      negs(1);
   endtask

   task automatic pulse(input logic [4:0] ev);
      {tmr2_evt, ser_evt, tmr1_evt, tmr0_evt, wdog_evt} = ev;
      negs(1);
      {tmr2_evt, ser_evt, tmr1_evt, tmr0_evt, wdog_evt} = '0;
      negs(1);
   endtask

   task automatic strobe_ack();
      irq_ack = 1; negs(1); irq_ack = 0;
   endtask

   task automatic strobe_ret();
      irq_ret = 1; negs(1); irq_ret = 0;
   endtask

   initial begin
      // R1: reset state
      do_reset();
      chk(irq_req == 0 && svc_active == 0, "R1 req/active", {irq_req, svc_active}, 0);
      chk(irq_vec == 0 && irq_lvl == 0, "R1 vec/lvl", {irq_vec, irq_lvl}, 0);

      // Table walk: R2, R3, R4, R5
      foreach (TBL[k]) begin
         do_reset();
         glob_en = TBL[k].g; src_en = TBL[k].en;
         prio_hi = TBL[k].hi; prio_lo = TBL[k].lo;
         pulse(TBL[k].ev);
         chk(irq_req == TBL[k].req, $sformatf("R%0d row %0d req", TBL[k].rq, k), irq_req, TBL[k].req);
         if (TBL[k].req) begin
            chk(irq_vec == TBL[k].vec && irq_lvl == TBL[k].lvl,
                $sformatf("R%0d row %0d vec/lvl", TBL[k].rq, k),
                {irq_vec, irq_lvl}, {TBL[k].vec, TBL[k].lvl});
         end
      end

      // R3: masked pending is kept and offered one edge after unmasking
      do_reset();
      glob_en = 1; src_en = 7'h00;
      pulse(5'b00010);
      chk(irq_req == 0, "R3 masked", irq_req, 0);
      src_en = 7'h04;
      negs(1);
      chk(irq_req == 1 && irq_vec == 16'h000B, "R3 unmasked", {irq_req, irq_vec}, {1'b1, 16'h000B});

      // R9, R8, R10, R11 nesting sequence
      do_reset();
      glob_en = 1; src_en = 7'h7F; prio_hi = 7'h40;
      pulse(5'b00010);
      chk(irq_req == 1 && irq_vec == 16'h000B, "R2 t0 offer", {irq_req, irq_vec}, {1'b1, 16'h000B});
      strobe_ack();
      chk(irq_req == 0 && irq_vec == 16'h000B && irq_lvl == 0, "R9 hold", {irq_req, irq_vec, irq_lvl}, {1'b0, 16'h000B, 2'd0});
      chk(svc_active == 1 && svc_lvl == 0, "R9 push", {svc_active, svc_lvl}, {1'b1, 2'd0});
      negs(1);
      chk(irq_req == 0, "R9 flag cleared", irq_req, 0);
      pulse(5'b00100);
      chk(irq_req == 0, "R8 equal level blocked", irq_req, 0);
      pulse(5'b10000);
      chk(irq_req == 1 && irq_vec == 16'h002B && irq_lvl == 2, "R8 preempt", {irq_req, irq_vec, irq_lvl}, {1'b1, 16'h002B, 2'd2});
      strobe_ack();
      chk(svc_lvl == 2, "R9 nested push", svc_lvl, 2);
      negs(1);
      chk(irq_req == 0, "R8 lower waits", irq_req, 0);
      strobe_ret();
      chk(svc_active == 1 && svc_lvl == 0, "R10 pop to 0", {svc_active, svc_lvl}, {1'b1, 2'd0});
      negs(1);
      chk(irq_req == 0, "R8 still blocked at 0", irq_req, 0);
      strobe_ret();
      chk(svc_active == 0, "R10 pop empty", svc_active, 0);
      negs(1);
      chk(irq_req == 1 && irq_vec == 16'h001B, "R10 waiting offered", {irq_req, irq_vec}, {1'b1, 16'h001B});
      strobe_ack();
      strobe_ret();
      chk(svc_active == 0, "R10 drained", svc_active, 0);
      strobe_ret();
      chk(svc_active == 0 && svc_lvl == 0, "R10 ret when empty", {svc_active, svc_lvl}, 0);
      strobe_ack();
      chk(svc_active == 0 && irq_req == 0, "R11 ack without req", {svc_active, irq_req}, 0);

      // R6: edge-triggered external 0
      do_reset();
      glob_en = 1; src_en = 7'h01; ext_edge_mode = 2'b01;
      ext_pin_n[0] = 0;
      negs(2);
      chk(irq_req == 1 && irq_vec == 16'h0003, "R6 edge offer", {irq_req, irq_vec}, {1'b1, 16'h0003});
      strobe_ack();
      strobe_ret();
      negs(2);
      chk(irq_req == 0, "R6 no retrigger while low", irq_req, 0);
      ext_pin_n[0] = 1; negs(1);
      ext_pin_n[0] = 0; negs(2);
      chk(irq_req == 1 && irq_vec == 16'h0003, "R6 second edge", {irq_req, irq_vec}, {1'b1, 16'h0003});

      // R7: level-triggered external 1
      do_reset();
      glob_en = 1; src_en = 7'h08; ext_edge_mode = 2'b00;
      ext_pin_n[1] = 0;
      negs(2);
      chk(irq_req == 1 && irq_vec == 16'h0013 && irq_lvl == 0, "R7 level offer", {irq_req, irq_vec}, {1'b1, 16'h0013});
      ext_pin_n[1] = 1;
      negs(2);
      chk(irq_req == 0, "R7 follows pin", irq_req, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule